// File: doc/BRIEF.md
# Two-Wire Register Slave for a Power Monitor

This block is the serial-bus front end of a power monitor. It gives a host access to two 16-bit words over a two-wire SMBus/I2C-compatible link. One word is a writable configuration word. The other is a read-only measurement word produced elsewhere in the chip. SCL and SDA are brought into the system clock domain through synchronizer flops. The block finds START, repeated START and STOP from the synchronized lines. It shifts bytes in on rising SCL and changes its SDA drive only after a falling SCL. It drives SDA open-drain style by means of a pull-low enable.

Each transfer is a word access. The host sends the device address with the write bit and then a one-byte command. It then either sends two data bytes, or issues a repeated START with the read bit and clocks two bytes out. The low byte always comes first, and each byte goes most significant bit first. The configuration word has one command code. Three separate measurement commands all return the same measurement word. The device address comes from a three-level board strap, which the block receives as a decoded 2-bit code.

When the high byte of a measurement read has left the block, a one-clock pulse tells the alert logic that the result has been consumed.

Top module: `smb_reg_slave`

## Requirements
- R1: After synchronous reset the configuration word is 0x0000, SDA is not driven and the read pulse is low.
- R2: The device answers only the address chosen by `strap_sel`: 2'b00 selects 0x70, 2'b01 selects 0x72, 2'b10 selects 0x76, and 2'b11 is treated like 2'b00. It does not acknowledge any other address.
- R3: A word write with command 0xD0 is acknowledged on all four bytes. It loads the configuration word with the low byte in bits 7:0 and the high byte in bits 15:8. The new value appears on `cfg_o` when the high byte has been received.
- R4: A word read with command 0xD0 returns the configuration word, low byte first, each byte MSB first.
- R5: Word reads with commands 0x8B, 0x8C and 0x96 all return `meas_val`.
- R6: A reserved code (0xD2 to 0xD5, 0xD7, 0xD8) or any other unsupported code is not acknowledged. The data bytes that follow it are not acknowledged and leave the configuration word unchanged.
- R7: `output_read` pulses high for exactly one clock after the high byte of a measurement read has been shifted out. It never pulses for a configuration read.
- R8: Data bytes written after a measurement command are not acknowledged and change nothing.
- R9: A write that ends with STOP before its high byte leaves the configuration word unchanged.
- R10: The SDA drive enable changes only while SCL is low.
- R11: Both bytes of a read come from one 16-bit value, captured when the address with the read bit is acknowledged, so a change of `meas_val` during the read does not tear the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_sel | input | 2 | Decoded address strap: 00 low, 01 open, 10 high |
| meas_val | input | 16 | Measurement word returned by the three read commands |
| cfg_o | output | 16 | Configuration word |
| output_read | output | 1 | One-clock pulse after a measurement read completes |

## Verification
Several cases are aimed at specific bugs. A reserved command code followed by data checks that a decoder which only rejected the command, but still latched the bytes after it, would be caught by a later read-back of the configuration word. A write cut short by STOP after the low byte exposes a design that commits half a word. A measurement word that changes between the two read bytes shows whether a design samples the live input per byte, which would return a torn value. Pulse counting around configuration and measurement reads catches an alert pulse that fires on the wrong command, or on the low byte instead of the high byte.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_CMD, ST_CACK,
    ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_WAIT
  } smb_state_t;

  localparam logic [7:0] CMD_CFG   = 8'hD0;
  localparam logic [7:0] CMD_VOLT  = 8'h8B;
  localparam logic [7:0] CMD_AMP   = 8'h8C;
  localparam logic [7:0] CMD_WATT  = 8'h96;

  function automatic logic [6:0] strap_addr(input logic [1:0] s);
    case (s)
      2'b01:   strap_addr = 7'h72;
      2'b10:   strap_addr = 7'h76;
      default: strap_addr = 7'h70;
    endcase
  endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_cmd_decode.sv
module smb_cmd_decode
  import smb_pkg::*;
(
  input  logic [7:0] code,
  output logic       valid,
  output logic       is_cfg
);
  always_comb begin
    is_cfg = (code == CMD_CFG);
    valid  = is_cfg || (code == CMD_VOLT) || (code == CMD_AMP) ||
             (code == CMD_WATT);
  end
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        strap_sel,
  input  logic [WORD_W-1:0] meas_val,
  output logic [WORD_W-1:0] cfg_o,
  output logic              output_read
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic dec_valid, dec_cfg;

  smb_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx, tx, hi_hold, lo_hold;
  logic              idx, rw, cmd_ok, cmd_cfg, rd_meas, mack;
  logic [6:0]        my_addr;
  logic [WORD_W-1:0] snap;

  smb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  smb_cmd_decode u_dec (.code(rx), .valid(dec_valid), .is_cfg(dec_cfg));

  assign my_addr = strap_addr(strap_sel);
  assign snap    = cmd_cfg ? cfg_o : meas_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      rx          <= '0;
      tx          <= '0;
      hi_hold     <= '0;
      lo_hold     <= '0;
      idx         <= 1'b0;
      rw          <= 1'b0;
      cmd_ok      <= 1'b0;
      cmd_cfg     <= 1'b0;
      rd_meas     <= 1'b0;
      mack        <= 1'b0;
      sda_oe      <= 1'b0;
      cfg_o       <= '0;
      output_read <= 1'b0;
    end else begin
      output_read <= 1'b0;
      if (stop_p) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        cmd_ok <= 1'b0;
      end else if (start_p) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_CMD, ST_WDAT: begin
            if (scl_rise) begin
              rx  <= {rx[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (rx[7:1] == my_addr && (!rx[0] || cmd_ok)) begin
                  sda_oe <= 1'b1;
                  rw     <= rx[0];
                  state  <= ST_AACK;
                end else begin
                  state <= ST_WAIT;
                end
              end else if (state == ST_CMD) begin
                cmd_ok  <= dec_valid;
                cmd_cfg <= dec_cfg;
                idx     <= 1'b0;
                sda_oe  <= dec_valid;
                state   <= dec_valid ? ST_CACK : ST_WAIT;
              end else begin
                if (cmd_cfg) begin
                  if (!idx) lo_hold <= rx;
                  else      cfg_o   <= {rx, lo_hold};
                  sda_oe <= 1'b1;
                  state  <= ST_WACK;
                end else begin
                  state <= ST_WAIT;
                end
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            cnt <= '0;
            idx <= 1'b0;
            if (rw) begin
              tx      <= snap[7:0];
              hi_hold <= snap[WORD_W-1:8];
              sda_oe  <= ~snap[7];
              rd_meas <= ~cmd_cfg;
              state   <= ST_RDAT;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_CMD;
            end
          end
          ST_CACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= ST_WDAT;
          end
          ST_WACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            idx    <= 1'b1;
            state  <= idx ? ST_WAIT : ST_WDAT;
          end
          ST_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
                if (idx && rd_meas) output_read <= 1'b1;
              end else begin
                sda_oe <= ~tx[BYTE_W-2];
                tx     <= {tx[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              cnt <= '0;
              if (mack && !idx) begin
                tx     <= hi_hold;
                sda_oe <= ~hi_hold[7];
                idx    <= 1'b1;
                state  <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [WORD_W-1:0] cfg_o,
  input logic              output_read
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cfg_o == '0 && !sda_oe && !output_read));

  assert_cfg_change_scl_low_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_o) |-> !scl_i);

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
    output_read |=> !output_read);

  assert_pulse_scl_low_R7: assert property (@(posedge clk) disable iff (rst)
    output_read |-> !scl_i);

  assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind smb_reg_slave smb_reg_slave_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .cfg_o(cfg_o), .output_read(output_read)
);

// File: tb/sim_smb_reg_slave.sv
module sim_smb_reg_slave;
  localparam int Q  = 16;
  localparam int NV = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] strap = 2'b00;
  logic [15:0] meas = 16'hA55A;
  logic sda_oe, oread;
  logic [15:0] cfg;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0, pulses = 0, bad_drive = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  smb_reg_slave u0 (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_sel(strap), .meas_val(meas), .cfg_o(cfg), .output_read(oread)
  );

  logic prev_oe = 1'b0;
  always @(posedge clk) begin
    if (oread) pulses <= pulses + 1;
    if (!rst && scl && sda_oe != prev_oe) bad_drive <= bad_drive + 1;
    prev_oe <= sda_oe;
  end

  // {op, cmd, data, expect}: op 0 = write (expect = ack mask {hi,lo,cmd,addr}), op 1 = read
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 8'hD0, 16'h1234, 16'h000F},
    {1'b1, 8'hD0, 16'h0000, 16'h1234},
    {1'b1, 8'h8B, 16'h0000, 16'hA55A},
    {1'b1, 8'h8C, 16'h0000, 16'hA55A},
    {1'b1, 8'h96, 16'h0000, 16'hA55A},
    {1'b0, 8'hD3, 16'hBEEF, 16'h0001},
    {1'b0, 8'hD8, 16'hCAFE, 16'h0001},
    {1'b1, 8'hD0, 16'h0000, 16'h1234},
    {1'b0, 8'h8B, 16'h5555, 16'h0003},
    {1'b1, 8'hD0, 16'h0000, 16'h1234},
    {1'b0, 8'hD0, 16'h80FF, 16'h000F}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bstart;
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bstop;
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_line;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic last);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(last);
  endtask

  task automatic word_write(input logic [6:0] a, input logic [7:0] c,
                            input logic [15:0] d, output logic [3:0] acks);
    bstart;
    send_byte({a, 1'b0}, acks[0]);
    send_byte(c, acks[1]);
    send_byte(d[7:0], acks[2]);
    send_byte(d[15:8], acks[3]);
    bstop;
  endtask

  task automatic word_read(input logic [6:0] a, input logic [7:0] c,
                           input logic [15:0] mid, output logic [15:0] v);
    logic k;
    bstart;
    send_byte({a, 1'b0}, k);
    send_byte(c, k);
    bstart;
    send_byte({a, 1'b1}, k);
    recv_byte(v[7:0], 1'b0);
    meas = mid;
    recv_byte(v[15:8], 1'b1);
    bstop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] acks;
    logic [15:0] v;
    int p0;
    tick(5);
    // R1 reset state
    chk("R1 cfg", cfg, 16'h0000);
    chk("R1 sda_oe", {15'd0, sda_oe}, 16'h0);
    chk("R1 pulse", {15'd0, oread}, 16'h0);
    rst = 1'b0;
    tick(5);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40] == 1'b0) begin
        word_write(7'h70, VEC[i][39:32], VEC[i][31:16], acks);
        if (VEC[i][3:0] == 4'hF)      chk("R3 acks", {12'd0, acks}, VEC[i][15:0]);
        else if (VEC[i][39:32] == 8'h8B) chk("R8 acks", {12'd0, acks}, VEC[i][15:0]);
        else                          chk("R6 acks", {12'd0, acks}, VEC[i][15:0]);
      end else begin
        word_read(7'h70, VEC[i][39:32], meas, v);
        if (VEC[i][39:32] == 8'hD0) chk("R4 read", v, VEC[i][15:0]);
        else                        chk("R5 read", v, VEC[i][15:0]);
      end
    end
    chk("R3 cfg_o", cfg, 16'h80FF);

    // R9 write cut short by STOP after low byte
    bstart;
    send_byte({7'h70, 1'b0}, acks[0]);
    send_byte(8'hD0, acks[1]);
    send_byte(8'h11, acks[2]);
    bstop;
    chk("R9 cfg kept", cfg, 16'h80FF);

    // R2 wrong address ignored, other strap codes
    word_write(7'h72, 8'hD0, 16'h0001, acks);
    chk("R2 foreign addr", {12'd0, acks}, 16'h0000);
    chk("R2 cfg kept", cfg, 16'h80FF);
    strap = 2'b01;
    word_write(7'h72, 8'hD0, 16'h0202, acks);
    chk("R2 open addr", {12'd0, acks}, 16'h000F);
    strap = 2'b10;
    word_write(7'h76, 8'hD0, 16'h0303, acks);
    chk("R2 high addr", {12'd0, acks}, 16'h000F);
    word_write(7'h70, 8'hD0, 16'h0404, acks);
    chk("R2 old addr", {12'd0, acks}, 16'h0000);
    strap = 2'b11;
    word_write(7'h70, 8'hD0, 16'h0505, acks);
    chk("R2 code 11", {12'd0, acks}, 16'h000F);
    chk("R2 cfg", cfg, 16'h0505);
    strap = 2'b00;

    // R7 pulse only for measurement reads
    p0 = pulses;
    word_read(7'h70, 8'hD0, meas, v);
    chk("R7 no pulse cfg read", 16'(pulses - p0), 16'd0);
    word_read(7'h70, 8'h96, meas, v);
    chk("R7 one pulse", 16'(pulses - p0), 16'd1);

    // R11 coherent word
    meas = 16'h1357;
    word_read(7'h70, 8'h8C, 16'hFFFF, v);
    chk("R11 no tear", v, 16'h1357);

    chk("R10 drive with SCL high", 16'(bad_drive), 16'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule